// File: doc/BRIEF.md
# Rotating-Seed Pseudo-Random Source for Stochastic Decoding

This block feeds a stochastic decoder with fresh pseudo-random bits on every enabled cycle. A 16-bit linear feedback shift register steps once per cycle. Its state is presented as two 8-bit random words. The low word drives a probability comparator. The high word is cut into two 3-bit addresses for 8-entry edge memories.

A single register sequence repeats after 2^16 − 1 steps. Long error-rate runs would then replay the same noise. To prevent this, the register is reloaded before the period completes, from a seed table of NUM_SEEDS entries. The table is split into a first group and a second group of equal size H = NUM_SEEDS/2. The loaded seed is the XOR of one entry from each group. The partner index in the second group is the first-group index plus a rotating offset, taken modulo H. The offset moves on each time the first-group index wraps, so all H² pairings are used before the sequence repeats. A controller may also request a reload at any time. The current group indices and offset are visible on ports.

Top module: `rng_reseed_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `idx_a`, `idx_b` and `pair_offset` are 0, and the register holds the seed for pairing (0,0).
- R2: In an enabled cycle with no reload, the state s moves to {s[14:0], s[15]^s[4]^s[2]^s[1]}, which is the polynomial x^16+x^5+x^3+x^2+1.
- R3: With `en` low and `reseed_req` low, the state, indices and offset all keep their values.
- R4: `rand_lo` is state bits [7:0] and `rand_hi` is state bits [15:8]. `em_addr_a` is `rand_hi`[2:0] and `em_addr_b` is `rand_hi`[5:3].
- R5: After a load, the register presents exactly STEP_LIMIT states over enabled cycles. The enabled cycle that would make the next step performs an automatic reload instead.
- R6: `reseed_req` high at a clock edge forces a reload at that edge, whether `en` is high or low, and restarts the step count.
- R7: Each reload increments `idx_a` modulo H. When `idx_a` wraps from H−1 to 0, `pair_offset` increments modulo H. `idx_b` always equals (`idx_a`+`pair_offset`) mod H.
- R8: The seed bank packs entry i at bits [16i+15:16i]. Entries 0..H−1 form the first group and entries H..NUM_SEEDS−1 form the second group. A reload loads first[idx_a] XOR second[idx_b]. If that XOR is zero, 16'hACE1 is loaded instead.
- R9: The register state is never all-zero.
- R10: H² consecutive reloads starting from pairing (0,0) visit every (`idx_a`, `pair_offset`) pair exactly once, and then return to (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step the register this cycle |
| reseed_req | input | 1 | Force a reload with the next pairing |
| rand_lo | output | 8 | Random word for the comparator |
| rand_hi | output | 8 | Random word that supplies the addresses |
| em_addr_a | output | ADDR_W | First edge-memory address |
| em_addr_b | output | ADDR_W | Second edge-memory address |
| idx_a | output | IDX_W | Current first-group index |
| idx_b | output | IDX_W | Current second-group index |
| pair_offset | output | IDX_W | Current rotation offset |

## Verification
The bench uses a seed table in which the first entries of both groups are equal, so the reset pairing XORs to zero. A design that skipped the substitution would lock into the all-zero state and emit zeros forever.

A short step limit makes automatic reloads frequent. A counter that is off by one shows up as one extra or one missing state before the pairing advances. Reload requests made with the enable low catch a design that gates requests behind the enable. Idle cycles then show whether anything drifts.

A run of exactly H² forced reloads checks the rotation. A design that advanced the offset on every reload, or that never wrapped it, would repeat a pairing or fail to return to (0,0).

// File: rtl/rng_pkg.sv
package rng_pkg;

    localparam int LFSR_W    = 16;
    localparam int RAND_W    = 8;
    localparam int MAX_SEEDS = 32;

    localparam logic [LFSR_W-1:0] ZERO_SUB = 16'hACE1;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef struct packed {
        logic [RAND_W-1:0] hi;
        logic [RAND_W-1:0] lo;
    } rand_split_t;

    // one step of x^16 + x^5 + x^3 + x^2 + 1, shifting toward the MSB
    function automatic lfsr_t lfsr_step(input lfsr_t s);
        logic fb;
        fb = s[15] ^ s[4] ^ s[2] ^ s[1];
        return {s[14:0], fb};
    endfunction

    // the all-zero state would lock the register
    function automatic lfsr_t seed_fix(input lfsr_t s);
        return (s == '0) ? ZERO_SUB : s;
    endfunction

    // default seed table: spaced points along one register sequence
    function automatic logic [LFSR_W*MAX_SEEDS-1:0] build_bank();
        logic [LFSR_W*MAX_SEEDS-1:0] b;
        lfsr_t v;
        b = '0;
        v = 16'h5EED;
        for (int i = 0; i < MAX_SEEDS; i++) begin
            for (int j = 0; j < 7; j++) begin
                v = lfsr_step(v);
            end
            b[LFSR_W*i +: LFSR_W] = v;
        end
        return b;
    endfunction

    localparam logic [LFSR_W*MAX_SEEDS-1:0] DEFAULT_BANK = build_bank();

endpackage

// File: rtl/rng_seed_rotator.sv
module rng_seed_rotator #(
    parameter int HALF       = 4,
    parameter int IDX_W      = 2,
    parameter int STEP_LIMIT = 65520,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             reseed_req,
    output logic [IDX_W-1:0] idx_a,
    output logic [IDX_W-1:0] idx_b,
    output logic [IDX_W-1:0] offset,
    output logic [IDX_W-1:0] nxt_a,
    output logic [IDX_W-1:0] nxt_b,
    output logic [CNT_W-1:0] step_cnt,
    output logic             reload
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_LIMIT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HALF - 1);
    localparam logic [IDX_W:0]   HALF_X   = (IDX_W+1)'(HALF);

    logic [IDX_W-1:0] a_q, off_q, a_d, off_d, a_inc, off_inc;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [IDX_W-1:0] add_mod(input logic [IDX_W-1:0] x,
                                                 input logic [IDX_W-1:0] y);
        logic [IDX_W:0] s;
        s = {1'b0, x} + {1'b0, y};
        if (s >= HALF_X) s = s - HALF_X;
        return s[IDX_W-1:0];
    endfunction

    always_comb begin
        reload  = reseed_req | (en & (cnt_q == CNT_LAST));
        a_inc   = (a_q == IDX_LAST)   ? '0 : a_q + 1'b1;
        off_inc = (off_q == IDX_LAST) ? '0 : off_q + 1'b1;
        if (rst) begin
            a_d   = '0;
            off_d = '0;
        end else if (reload) begin
            a_d   = a_inc;
            off_d = (a_q == IDX_LAST) ? off_inc : off_q;
        end else begin
            a_d   = a_q;
            off_d = off_q;
        end
    end

    always_ff @(posedge clk) begin
        a_q   <= a_d;
        off_q <= off_d;
        if (rst || reload) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idx_a    = a_q;
    assign offset   = off_q;
    assign idx_b    = add_mod(a_q, off_q);
    assign nxt_a    = a_d;
    assign nxt_b    = add_mod(a_d, off_d);
    assign step_cnt = cnt_q;

endmodule

// File: rtl/rng_seed_select.sv
module rng_seed_select #(
    parameter int HALF  = 4,
    parameter int IDX_W = 2,
    parameter logic [rng_pkg::LFSR_W*2*HALF-1:0] SEED_BANK = '1
) (
    input  logic [IDX_W-1:0]   sel_a,
    input  logic [IDX_W-1:0]   sel_b,
    output rng_pkg::lfsr_t     seed
);

    localparam int W = rng_pkg::LFSR_W;

    rng_pkg::lfsr_t grp_a [HALF];
    rng_pkg::lfsr_t grp_b [HALF];

    for (genvar g = 0; g < HALF; g++) begin : g_unpack
        assign grp_a[g] = SEED_BANK[W*g +: W];
        assign grp_b[g] = SEED_BANK[W*(HALF+g) +: W];
    end

    assign seed = rng_pkg::seed_fix(grp_a[sel_a] ^ grp_b[sel_b]);

endmodule

// File: rtl/rng_lfsr_core.sv
module rng_lfsr_core (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  rng_pkg::lfsr_t seed,
    output rng_pkg::lfsr_t state
);

    rng_pkg::lfsr_t q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            q <= seed;
        end else if (step) begin
            q <= rng_pkg::lfsr_step(q);
        end
    end

    assign state = q;

endmodule

// File: rtl/rng_field_split.sv
module rng_field_split #(
    parameter int ADDR_W = 3
) (
    input  rng_pkg::lfsr_t                 state,
    output logic [rng_pkg::RAND_W-1:0]     rand_lo,
    output logic [rng_pkg::RAND_W-1:0]     rand_hi,
    output logic [ADDR_W-1:0]              em_addr_a,
    output logic [ADDR_W-1:0]              em_addr_b
);

    rng_pkg::rand_split_t parts;

    assign parts     = state;
    assign rand_lo   = parts.lo;
    assign rand_hi   = parts.hi;
    assign em_addr_a = parts.hi[ADDR_W-1:0];
    assign em_addr_b = parts.hi[2*ADDR_W-1:ADDR_W];

endmodule

// File: rtl/rng_reseed_top.sv
module rng_reseed_top #(
    parameter int NUM_SEEDS  = 8,
    parameter int STEP_LIMIT = 65520,
    parameter int ADDR_W     = 3,
    parameter logic [rng_pkg::LFSR_W*NUM_SEEDS-1:0] SEED_BANK =
        rng_pkg::DEFAULT_BANK[rng_pkg::LFSR_W*NUM_SEEDS-1:0],
    localparam int HALF  = NUM_SEEDS / 2,
    localparam int IDX_W = (HALF > 1) ? $clog2(HALF) : 1,
    localparam int CNT_W = $clog2(STEP_LIMIT + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        reseed_req,
    output logic [rng_pkg::RAND_W-1:0]  rand_lo,
    output logic [rng_pkg::RAND_W-1:0]  rand_hi,
    output logic [ADDR_W-1:0]           em_addr_a,
    output logic [ADDR_W-1:0]           em_addr_b,
    output logic [IDX_W-1:0]            idx_a,
    output logic [IDX_W-1:0]            idx_b,
    output logic [IDX_W-1:0]            pair_offset
);

    logic [IDX_W-1:0] nxt_a, nxt_b;
    logic [CNT_W-1:0] step_cnt;
    logic             reload;
    rng_pkg::lfsr_t   seed;
    rng_pkg::lfsr_t   lfsr_q;

    rng_seed_rotator #(
        .HALF(HALF), .IDX_W(IDX_W), .STEP_LIMIT(STEP_LIMIT), .CNT_W(CNT_W)
    ) u_rot (
        .clk(clk), .rst(rst), .en(en), .reseed_req(reseed_req),
        .idx_a(idx_a), .idx_b(idx_b), .offset(pair_offset),
        .nxt_a(nxt_a), .nxt_b(nxt_b), .step_cnt(step_cnt), .reload(reload)
    );

    rng_seed_select #(
        .HALF(HALF), .IDX_W(IDX_W), .SEED_BANK(SEED_BANK)
    ) u_sel (
        .sel_a(nxt_a), .sel_b(nxt_b), .seed(seed)
    );

    rng_lfsr_core u_core (
        .clk(clk), .rst(rst), .load(reload), .step(en),
        .seed(seed), .state(lfsr_q)
    );

    rng_field_split #(.ADDR_W(ADDR_W)) u_split (
        .state(lfsr_q), .rand_lo(rand_lo), .rand_hi(rand_hi),
        .em_addr_a(em_addr_a), .em_addr_b(em_addr_b)
    );

endmodule

// File: rtl/rng_reseed_chk.sv
module rng_reseed_chk #(
    parameter int HALF       = 4,
    parameter int IDX_W      = 2,
    parameter int CNT_W      = 16,
    parameter int STEP_LIMIT = 65520
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             reseed_req,
    input rng_pkg::lfsr_t   state,
    input logic [IDX_W-1:0] idx_a,
    input logic [IDX_W-1:0] idx_b,
    input logic [IDX_W-1:0] offset,
    input logic [CNT_W-1:0] step_cnt
);

    a_r9_never_zero: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !reseed_req) |=> ($stable(state) && $stable(idx_a) && $stable(offset)));

    a_r6_req_restart: assert property (@(posedge clk) disable iff (rst)
        reseed_req |=> (step_cnt == '0));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        int'(step_cnt) < STEP_LIMIT);

    a_r7_req_advance: assert property (@(posedge clk) disable iff (rst)
        reseed_req |=> (int'(idx_a) == ((int'($past(idx_a)) + 1) % HALF)));

    a_r7_offset_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(offset) |-> (idx_a == '0));

    a_r2_plain_step: assert property (@(posedge clk) disable iff (rst)
        (en && !reseed_req && int'(step_cnt) != STEP_LIMIT - 1)
        |=> (state == rng_pkg::lfsr_step($past(state))));

endmodule

bind rng_reseed_top rng_reseed_chk #(
    .HALF(HALF), .IDX_W(IDX_W), .CNT_W(CNT_W), .STEP_LIMIT(STEP_LIMIT)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .reseed_req(reseed_req),
    .state(lfsr_q), .idx_a(idx_a), .idx_b(idx_b), .offset(pair_offset),
    .step_cnt(step_cnt)
);

// File: tb/sim_rng_reseed_top.sv
`timescale 1ns/1ps
module sim_rng_reseed_top;

    localparam int K     = 8;
    localparam int H     = 4;
    localparam int LIMIT = 12;
    // second group entries 3..0, then first group entries 3..0; A0 == B0
    localparam logic [16*K-1:0] BANK = {
        16'hC003, 16'h0F0F, 16'h5A5A, 16'h1111,
        16'h00FF, 16'h8001, 16'h2345, 16'h1111
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic reseed_req = 1'b0;
    logic [7:0] rand_lo, rand_hi;
    logic [2:0] em_addr_a, em_addr_b;
    logic [1:0] idx_a, idx_b, pair_offset;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] m_state;
    int m_a, m_off, m_cnt;

    always #2 clk = ~clk;

    rng_reseed_top #(.NUM_SEEDS(K), .STEP_LIMIT(LIMIT), .ADDR_W(3), .SEED_BANK(BANK)) u0 (
        .clk(clk), .rst(rst), .en(en), .reseed_req(reseed_req),
        .rand_lo(rand_lo), .rand_hi(rand_hi),
        .em_addr_a(em_addr_a), .em_addr_b(em_addr_b),
        .idx_a(idx_a), .idx_b(idx_b), .pair_offset(pair_offset)
    );

    function automatic logic [15:0] b_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    endfunction

    function automatic logic [15:0] b_seed(input int a, input int off);
        logic [15:0] x;
        x = BANK[16*a +: 16] ^ BANK[16*(H + ((a + off) % H)) +: 16];
        return (x == 16'h0) ? 16'hACE1 : x;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(rand_lo == m_state[7:0], "R2 rand_lo", rand_lo, m_state[7:0]);
        chk(rand_hi == m_state[15:8], "R4 rand_hi", rand_hi, m_state[15:8]);
        chk(em_addr_a == m_state[10:8], "R4 em_addr_a", em_addr_a, m_state[10:8]);
        chk(em_addr_b == m_state[13:11], "R4 em_addr_b", em_addr_b, m_state[13:11]);
        chk(int'(idx_a) == m_a, "R7 idx_a", idx_a, m_a);
        chk(int'(pair_offset) == m_off, "R7 offset", pair_offset, m_off);
        chk(int'(idx_b) == (m_a + m_off) % H, "R7 idx_b", idx_b, (m_a + m_off) % H);
        chk({rand_hi, rand_lo} != 16'h0, "R9 nonzero", {rand_hi, rand_lo}, 1);
    endtask

    task automatic model_next(input bit e, input bit r);
        if (r || (e && m_cnt == LIMIT - 1)) begin
            if (m_a == H - 1) begin
                m_a = 0;
                m_off = (m_off + 1) % H;
            end else begin
                m_a = m_a + 1;
            end
            m_state = b_seed(m_a, m_off);
            m_cnt = 0;
        end else if (e) begin
            m_state = b_step(m_state);
            m_cnt++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en = 1'b0;
        reseed_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_a = 0;
        m_off = 0;
        m_cnt = 0;
        m_state = b_seed(0, 0);
        // R1 / R8: pairing (0,0) XORs to zero and must be substituted
        chk({rand_hi, rand_lo} == 16'hACE1, "R1 R8 reset seed", {rand_hi, rand_lo}, 16'hACE1);
        chk(idx_a == 0 && idx_b == 0 && pair_offset == 0, "R1 indices", {idx_a, idx_b, pair_offset}, 0);
    endtask

    task automatic cycle(input bit e, input bit r);
        en = e;
        reseed_req = r;
        model_next(e, r);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        bit visited [H*H];
        logic [15:0] held;
        int distinct;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        check_all();

        // R5: free-running enable crosses several automatic reloads
        for (int i = 0; i < 3 * LIMIT + 5; i++) cycle(1'b1, 1'b0);

        // R5 directed: exactly LIMIT states per seed
        do_reset();
        for (int i = 0; i < LIMIT - 1; i++) cycle(1'b1, 1'b0);
        chk(int'(idx_a) == 0, "R5 no early reload", idx_a, 0);
        cycle(1'b1, 1'b0);
        chk(int'(idx_a) == 1, "R5 reload at limit", idx_a, 1);
        chk({rand_hi, rand_lo} == b_seed(1, 0), "R8 pair (1,0) seed",
            {rand_hi, rand_lo}, b_seed(1, 0));

        // R6: request with enable low still reloads; R3: idle holds
        cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b1);
        chk(int'(idx_a) == 2, "R6 request without enable", idx_a, 2);
        held = {rand_hi, rand_lo};
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);
        chk({rand_hi, rand_lo} == held, "R3 idle hold", {rand_hi, rand_lo}, held);
        // R6: count restarted, so LIMIT-1 more steps stay on this pairing
        for (int i = 0; i < LIMIT - 1; i++) cycle(1'b1, 1'b0);
        chk(int'(idx_a) == 2, "R6 count restarted", idx_a, 2);

        // mixed random stimulus
        for (int i = 0; i < 400; i++) begin
            cycle(($urandom % 10) < 7, ($urandom % 20) == 0);
        end

        // R10: full rotation through all H*H pairings
        do_reset();
        for (int i = 0; i < H * H; i++) visited[i] = 1'b0;
        for (int i = 0; i < H * H; i++) begin
            visited[int'(idx_a) * H + int'(pair_offset)] = 1'b1;
            cycle(1'b0, 1'b1);
        end
        distinct = 0;
        for (int i = 0; i < H * H; i++) if (visited[i]) distinct++;
        chk(distinct == H * H, "R10 all pairings", distinct, H * H);
        chk(idx_a == 0 && pair_offset == 0, "R10 return to start", {idx_a, pair_offset}, 0);

        // R1: reset in mid-run
        for (int i = 0; i < 30; i++) cycle(1'b1, ($urandom % 8) == 0);
        do_reset();
        check_all();

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule